// File: doc/BRIEF.md
# NAND Hamming Parity Accumulator

This block builds the single-error-correcting Hamming parity of one NAND data block while the bytes stream past on their way to or from the flash. Every data bit has a twelve-bit address: the byte position within the block in the upper nine bits and the bit position within the byte in the lower three. For each address bit the block keeps two running parities. The even parity covers the bits whose address bit is zero, and the odd parity covers the bits whose address bit is one. The three low address bits give the column parities P1, P2 and P4. The byte-position bits give the row parities P8 up to P2048.

Software pulses the clear input before each block. It then presents the block one byte per strobe on an 8-bit bus, or two bytes per strobe on a 16-bit bus. When the last byte of the block has been taken, the block raises done. From then on it holds a 32-bit result word and a three-byte packed code until the next clear. The parities are not inverted, so an erased block of all-ones data gives a code of all zeros.

Top module: `nand_hecc_acc`

## Requirements
- R1: After reset, result_o and ecc_o are zero and done_o is low.
- R2: Bit i of a byte at block position a has address {a, i}, where i = 0 is the byte's least significant bit. A set bit toggles the even parity of every address bit that is 0 and the odd parity of every address bit that is 1.
- R3: result_o bit k (k = 0..11) holds the even parity of address bit k, and result_o bit 16+k holds its odd parity. Bits 15:12 and 31:28 are always zero.
- R4: ecc_o[7:0] equals result_o[7:0] and ecc_o[15:8] equals result_o[23:16]. ecc_o[23:16] has result_o[27:24] in its upper nibble and result_o[11:8] in its lower nibble.
- R5: The parities are not inverted: a block of 512 bytes of 0xFF gives a result and a code of zero.
- R6: When wide_i = 0, each accepted strobe takes one byte from data_i[7:0]. The first byte after a clear is at position 0, and each later byte is at the next position.
- R7: When wide_i = 1, each accepted strobe takes two bytes: data_i[7:0] at position 2n and data_i[15:8] at position 2n+1. When wide_i = 0, data_i[15:8] has no effect.
- R8: done_o rises in the cycle after the strobe that delivers byte 512 and stays low before that. While done_o is high, strobes are ignored and the result holds until a clear.
- R9: A clear sets the parities, the byte position and done_o to zero in the next cycle. A strobe in the same cycle as a clear is discarded.
- R10: A strobe with en_i low, or a cycle with stb_i low, changes neither the parities nor the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear accumulated parity and begin a new block |
| en_i | input | 1 | Accumulation enable |
| stb_i | input | 1 | Data strobe |
| wide_i | input | 1 | Bus width: 0 = 8-bit, 1 = 16-bit |
| data_i | input | 16 | Byte or halfword of block data |
| result_o | output | 32 | Even and odd parity word |
| ecc_o | output | 24 | Packed three-byte code |
| done_o | output | 1 | Full block accumulated |

## Verification
Two functions can land on the same clock edge: a clear and a data strobe, and a data strobe and the end of the block. The bench drives a clear with an accepted strobe carrying 0x01 in the same cycle. It then expects the result to be zero. It also expects the next byte to land at position 0, which shows up as the pattern 0x00000FFF. After a full block, a further strobe must leave both the result and done unchanged.

// File: rtl/nand_hecc_pkg.sv
package nand_hecc_pkg;

    localparam int BYTE_W     = 8;
    localparam int COL_BITS   = 3;
    localparam int RES_W      = 32;
    localparam int ODD_OFS    = 16;
    localparam int CODE_W     = 24;

    typedef enum logic {
        BUS_X8  = 1'b0,
        BUS_X16 = 1'b1
    } bus_width_e;

    // Mask of the byte bits whose bit index has bit k set.
    function automatic logic [BYTE_W-1:0] col_mask(input int k);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_hecc_byte_par.sv
module nand_hecc_byte_par
    import nand_hecc_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int PAR_N = ADDR_W + COL_BITS
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] pos_i,
    input  logic              act_i,
    output logic [PAR_N-1:0]  even_o,
    output logic [PAR_N-1:0]  odd_o
);

    logic byte_par;
    assign byte_par = ^byte_i;

    for (genvar k = 0; k < PAR_N; k++) begin : g_par
        if (k < COL_BITS) begin : g_col
            localparam logic [BYTE_W-1:0] MASK_HI = col_mask(k);
            assign odd_o[k]  = act_i & (^(byte_i & MASK_HI));
            assign even_o[k] = act_i & (^(byte_i & ~MASK_HI));
        end else begin : g_row
            assign odd_o[k]  = act_i & byte_par & pos_i[k-COL_BITS];
            assign even_o[k] = act_i & byte_par & ~pos_i[k-COL_BITS];
        end
    end

endmodule

// File: rtl/nand_hecc_pack.sv
module nand_hecc_pack
    import nand_hecc_pkg::*;
(
    input  logic [RES_W-1:0]  result_i,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        code_o[7:0]   = result_i[7:0];
        code_o[15:8]  = result_i[ODD_OFS+7:ODD_OFS];
        code_o[23:16] = {result_i[ODD_OFS+11:ODD_OFS+8], result_i[11:8]};
    end

endmodule

// File: rtl/nand_hecc_acc.sv
module nand_hecc_acc
    import nand_hecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic        stb_i,
    input  logic        wide_i,
    input  logic [15:0] data_i,
    output logic [31:0] result_o,
    output logic [23:0] ecc_o,
    output logic        done_o
);

    localparam int ADDR_W = $clog2(BLOCK_BYTES);
    localparam int PAR_N  = ADDR_W + COL_BITS;
    localparam int CNT_W  = ADDR_W + 1;
    localparam int LANES  = 2;

    typedef struct packed {
        logic [PAR_N-1:0] even;
        logic [PAR_N-1:0] odd;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } state_t;

    state_t     st_d, st_q;
    bus_width_e bus_w;
    logic       take;

    logic [PAR_N-1:0] lane_even [LANES];
    logic [PAR_N-1:0] lane_odd  [LANES];

    assign bus_w = bus_width_e'(wide_i);
    assign take  = en_i & stb_i & ~st_q.done & ~clr_i;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ADDR_W-1:0] pos;
        logic              act;
        assign pos = st_q.cnt[ADDR_W-1:0] + ADDR_W'(l);
        assign act = take & ((l == 0) | (bus_w == BUS_X16));
        nand_hecc_byte_par #(.ADDR_W(ADDR_W)) u_par (
            .byte_i (data_i[BYTE_W*l +: BYTE_W]),
            .pos_i  (pos),
            .act_i  (act),
            .even_o (lane_even[l]),
            .odd_o  (lane_odd[l])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (take) begin
            st_d.even = st_q.even ^ lane_even[0] ^ lane_even[1];
            st_d.odd  = st_q.odd  ^ lane_odd[0]  ^ lane_odd[1];
            st_d.cnt  = st_q.cnt + ((bus_w == BUS_X16) ? CNT_W'(2) : CNT_W'(1));
            st_d.done = (st_d.cnt >= CNT_W'(BLOCK_BYTES));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        result_o = '0;
        result_o[PAR_N-1:0]           = st_q.even;
        result_o[ODD_OFS +: PAR_N]    = st_q.odd;
    end

    assign done_o = st_q.done;

    nand_hecc_pack u_pack (
        .result_i (result_o),
        .code_o   (ecc_o)
    );

endmodule

// File: rtl/nand_hecc_chk.sv
module nand_hecc_chk #(
    parameter int PAR_N = 12
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        clr_i,
    input logic        en_i,
    input logic        stb_i,
    input logic        wide_i,
    input logic [15:0] data_i,
    input logic [31:0] result_o,
    input logic [23:0] ecc_o,
    input logic        done_o
);

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (result_o == 32'h0) && !done_o);

    p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !clr_i) |=> done_o && $stable(result_o));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !(en_i && stb_i)) |=> $stable(result_o) && $stable(done_o));

    p_pad_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (result_o[15:PAR_N] == '0) && (result_o[31:16+PAR_N] == '0));

    p_pack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ecc_o == {result_o[27:24], result_o[11:8], result_o[23:16], result_o[7:0]});

    // Each row parity pair absorbs the byte parity exactly once per narrow byte (R2).
    p_row_split_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && stb_i && !wide_i && !clr_i && !done_o) |=>
        ((result_o[PAR_N-1:3] ^ result_o[16+PAR_N-1:19]) ==
         ($past(result_o[PAR_N-1:3] ^ result_o[16+PAR_N-1:19]) ^
          {(PAR_N-3){^$past(data_i[7:0])}})));

endmodule

bind nand_hecc_acc nand_hecc_chk #(.PAR_N(PAR_N)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .en_i     (en_i),
    .stb_i    (stb_i),
    .wide_i   (wide_i),
    .data_i   (data_i),
    .result_o (result_o),
    .ecc_o    (ecc_o),
    .done_o   (done_o)
);

// File: tb/nand_hecc_acc_tb.sv
module nand_hecc_acc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        stb = 1'b0;
    logic        wide = 1'b0;
    logic [15:0] data = 16'h0;
    logic [31:0] result;
    logic [23:0] ecc;
    logic        done;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [512];

    always #4 clk = ~clk;

    nand_hecc_acc u_dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en), .stb_i(stb),
        .wide_i(wide), .data_i(data), .result_o(result), .ecc_o(ecc), .done_o(done)
    );

    // {wide, byte position, data}
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 9'd0,   16'h0001},
        {1'b0, 9'd511, 16'h0080},
        {1'b0, 9'h155, 16'h0010},
        {1'b0, 9'h0AA, 16'h005A},
        {1'b1, 9'd0,   16'h0100},
        {1'b1, 9'd510, 16'h8000},
        {1'b1, 9'h124, 16'h00C3},
        {1'b1, 9'h0FE, 16'hA5FF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model();
        logic [31:0] r = 32'h0;
        for (int a = 0; a < 512; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[a][b]) begin
                    logic [11:0] adr;
                    adr = {a[8:0], b[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (adr[k]) r[16+k] = ~r[16+k];
                        else        r[k]    = ~r[k];
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [23:0] pack(input logic [31:0] r);
        return {r[27:24], r[11:8], r[23:16], r[7:0]};
    endfunction

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic feed(input bit w, input int count);
        if (w) begin
            for (int i = 0; i < count; i++) begin
                @(negedge clk);
                en = 1'b1; stb = 1'b1; wide = 1'b1;
                data = {mem[2*i+1], mem[2*i]};
            end
        end else begin
            for (int i = 0; i < count; i++) begin
                @(negedge clk);
                en = 1'b1; stb = 1'b1; wide = 1'b0;
                data = {8'hA5 ^ i[7:0], mem[i]};
            end
        end
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic full_block(input bit w, input string req);
        logic [31:0] exp;
        exp = model();
        do_clear();
        feed(w, w ? 256 : 512);
        chk(result === exp, req, result, exp);
        chk(ecc === pack(exp), "R4", {8'h0, ecc}, {8'h0, pack(exp)});
        chk(done === 1'b1, "R8", {31'h0, done}, 32'h1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(result === 32'h0 && ecc === 24'h0, "R1", result, 32'h0);
        chk(done === 1'b0, "R1", {31'h0, done}, 32'h0);
        rst_n = 1'b1;

        // Vector table: single non-zero word in an otherwise zero block (R2 R3 R6 R7)
        for (int v = 0; v < 8; v++) begin
            logic [25:0] e;
            e = VEC[v];
            for (int a = 0; a < 512; a++) mem[a] = 8'h00;
            mem[e[24:16]] = e[7:0];
            if (e[25]) mem[e[24:16] + 9'd1] = e[15:8];
            full_block(e[25], e[25] ? "R7" : "R6");
        end

        // Erased block, both widths (R5)
        for (int a = 0; a < 512; a++) mem[a] = 8'hFF;
        full_block(1'b0, "R5");
        chk(result === 32'h0, "R5", result, 32'h0);
        full_block(1'b1, "R5");

        // Pseudo-random block, both widths (R2)
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int a = 0; a < 512; a++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                mem[a] = lfsr[7:0];
            end
        end
        full_block(1'b0, "R2");
        full_block(1'b1, "R2");

        // Done must stay low until byte 512 (R8)
        for (int a = 0; a < 512; a++) mem[a] = 8'h00;
        mem[511] = 8'h01;
        do_clear();
        feed(1'b0, 511);
        chk(done === 1'b0, "R8", {31'h0, done}, 32'h0);
        chk(result === 32'h0, "R8", result, 32'h0);
        @(negedge clk); stb = 1'b1; data = 16'h0001;
        @(negedge clk); stb = 1'b0;
        chk(done === 1'b1, "R8", {31'h0, done}, 32'h1);
        chk(result === model(), "R8", result, model());

        // Strobe after done is ignored (R8)
        @(negedge clk); stb = 1'b1; data = 16'h0001;
        @(negedge clk); stb = 1'b0;
        chk(result === model() && done === 1'b1, "R8", result, model());

        // Clear and strobe in the same cycle: strobe discarded (R9)
        @(negedge clk); clr = 1'b1; en = 1'b1; stb = 1'b1; wide = 1'b0; data = 16'h0001;
        @(negedge clk); clr = 1'b0; stb = 1'b0;
        chk(result === 32'h0 && done === 1'b0, "R9", result, 32'h0);
        @(negedge clk); stb = 1'b1; data = 16'h0001;
        @(negedge clk); stb = 1'b0;
        chk(result === 32'h0000_0FFF, "R9", result, 32'h0000_0FFF);

        // Enable low and strobe low are ignored (R10)
        do_clear();
        @(negedge clk); en = 1'b0; stb = 1'b1; data = 16'h00FF;
        @(negedge clk); stb = 1'b0;
        chk(result === 32'h0, "R10", result, 32'h0);
        @(negedge clk); en = 1'b1; stb = 1'b0; data = 16'h00FF;
        @(negedge clk);
        chk(result === 32'h0, "R10", result, 32'h0);
        for (int a = 0; a < 512; a++) mem[a] = 8'h00;
        mem[0] = 8'h80;
        feed(1'b0, 512);
        chk(result === model(), "R10", result, model());

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule